// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block is the arithmetic core beside an 8-bit accumulator machine. In one cycle it takes the accumulator value, a second operand, an operation code and the current status word. It returns the new accumulator, the new second register and the new status word. The operations are add, add with carry-in, subtract with borrow-in, unsigned multiply and unsigned divide. It can also set or clear the carry flag directly, and it can copy the operand into the accumulator. Multiply and divide split their results across the accumulator and the second register.

The status word keeps a fixed bit layout, from bit 7 down to bit 0: carry, half carry, user flag, bank select high, bank select low, overflow, spare, parity. The unit writes only carry, half carry, overflow and parity. The other four bits come back exactly as they went in. The parity bit always reflects the accumulator value the unit returns.

Results are registered. A request with `op_valid` high gives `res_valid` high on the next cycle. Between requests the outputs hold their values.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid`, `a_out`, `b_out` and `psw_out` become zero.
- R2: A request accepted at one rising edge (`op_valid`=1) shows its result with `res_valid`=1 after that edge. An edge with `op_valid`=0 drives `res_valid` to 0 and leaves `a_out`, `b_out` and `psw_out` unchanged. Operation codes: 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide, 5 set carry, 6 clear carry, 7 copy operand to accumulator.
- R3: Add (0) and add with carry (1) return `a_out` = the low 8 bits of A+B (+carry for code 1) and `b_out` = B. Carry (bit 7) is the carry out of bit 7.
- R4: For add, add with carry and subtract with borrow, half carry (bit 6) is 1 exactly when bit 3 carries into bit 4, or when bit 4 borrows from bit 3.
- R5: For the same three operations, overflow (bit 2) is 1 exactly when the two's-complement result falls outside -128..127.
- R6: Subtract with borrow (2) returns `a_out` = the low 8 bits of A-B-carry. Carry is 1 exactly when that difference is negative.
- R7: Multiply (3) returns the low product byte in `a_out` and the high byte in `b_out`. Overflow is 1 when the product exceeds 255. Carry is 0.
- R8: Divide (4) with B≠0 returns the quotient in `a_out` and the remainder in `b_out`. Overflow and carry are 0.
- R9: Divide with B=0 returns `a_out`=A and `b_out`=B, with overflow 1 and carry 0.
- R10: Set carry (5) and clear carry (6) change only bit 7. A, B, half carry and overflow pass through.
- R11: Parity (bit 0) of `psw_out` is the XOR of all bits of `a_out` after every operation, including copy (7), which returns `a_out`=B.
- R12: Bits 5, 4, 3 and 1 of `psw_out` equal the same bits of `psw_in` for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 3 | Operation select |
| a_in | input | W | Accumulator operand |
| b_in | input | W | Second operand |
| psw_in | input | 8 | Current status word |
| res_valid | output | 1 | Result strobe, one cycle after request |
| a_out | output | W | New accumulator |
| b_out | output | W | New second register |
| psw_out | output | 8 | New status word |

## Verification
The bench builds the unit with the default width W=8. At that width the flag boundaries land on familiar values: 0x7F+1 for signed overflow, 0x0F+1 for half carry, 0xFF+1 for carry, and products above 255 for multiply overflow. Back-to-back requests cover the single-cycle latency. An idle gap checks that the outputs hold. A divide by zero with carry set shows both the guarded path and the forced carry clear.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_SETC = 3'd5,
    OP_CLRC = 3'd6,
    OP_MOVA = 3'd7
  } alu_op_e;

  localparam int PSW_W  = 8;
  localparam int PSW_CY = 7;
  localparam int PSW_AC = 6;
  localparam int PSW_OV = 2;
  localparam int PSW_P  = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int NIB = W / 2;

  logic [W-1:0] opb;
  logic         ci;
  logic [W:0]   full;
  logic [NIB:0] lo;

  // subtraction is a + ~b + ~borrow; carry outputs invert to borrows
  assign opb  = sub ? ~b : b;
  assign ci   = sub ? ~cin : cin;
  assign full = {1'b0, a} + {1'b0, opb} + {{W{1'b0}}, ci};
  assign lo   = {1'b0, a[NIB-1:0]} + {1'b0, opb[NIB-1:0]} + {{NIB{1'b0}}, ci};

  assign res = full[W-1:0];
  assign cy  = sub ? ~full[W] : full[W];
  assign ac  = sub ? ~lo[NIB] : lo[NIB];
  assign ov  = (a[W-1] == opb[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           dz
);
  logic [W-1:0] part [0:W];

  assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign dz      = (b == '0);
  assign part[0] = '0;

  // restoring divider, one stage per dividend bit, msb first
  for (genvar k = 0; k < W; k++) begin : g_stage
    logic [W:0] trial;
    logic       ge;
    assign trial = {part[k], a[W-1-k]};
    assign ge    = trial >= {1'b0, b};
    assign quo[W-1-k] = ge;
    assign part[k+1]  = ge ? (trial[W-1:0] - b) : trial[W-1:0];
  end

  assign rem = part[W];
endmodule

// File: rtl/alu_parity.sv
module alu_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         odd
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ d[i];
  end
  assign odd = chain[W];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [PSW_W-1:0] psw_in,
  output logic             res_valid,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     b_out,
  output logic [PSW_W-1:0] psw_out
);
  alu_op_e op;
  assign op = alu_op_e'(op_code);

  logic         as_sub, as_cin;
  logic [W-1:0] as_res;
  logic         as_cy, as_ac, as_ov;

  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : psw_in[PSW_CY];

  alu_addsub #(.W(W)) u_addsub (
    .a(a_in), .b(b_in), .cin(as_cin), .sub(as_sub),
    .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  logic [2*W-1:0] md_prod;
  logic [W-1:0]   md_quo, md_rem;
  logic           md_dz;

  alu_muldiv #(.W(W)) u_muldiv (
    .a(a_in), .b(b_in),
    .prod(md_prod), .quo(md_quo), .rem(md_rem), .dz(md_dz)
  );

  logic [W-1:0] nxt_a, nxt_b;
  logic         nxt_cy, nxt_ac, nxt_ov, nxt_p;

  always_comb begin
    nxt_a  = a_in;
    nxt_b  = b_in;
    nxt_cy = psw_in[PSW_CY];
    nxt_ac = psw_in[PSW_AC];
    nxt_ov = psw_in[PSW_OV];
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nxt_a  = as_res;
        nxt_cy = as_cy;
        nxt_ac = as_ac;
        nxt_ov = as_ov;
      end
      OP_MUL: begin
        nxt_a  = md_prod[W-1:0];
        nxt_b  = md_prod[2*W-1:W];
        nxt_cy = 1'b0;
        nxt_ov = |md_prod[2*W-1:W];
      end
      OP_DIV: begin
        nxt_cy = 1'b0;
        nxt_ov = md_dz;
        if (!md_dz) begin
          nxt_a = md_quo;
          nxt_b = md_rem;
        end
      end
      OP_SETC: nxt_cy = 1'b1;
      OP_CLRC: nxt_cy = 1'b0;
      OP_MOVA: nxt_a  = b_in;
      default: ;
    endcase
  end

  alu_parity #(.W(W)) u_parity (.d(nxt_a), .odd(nxt_p));

  logic unused_old_p;
  assign unused_old_p = psw_in[PSW_P];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      a_out     <= '0;
      b_out     <= '0;
      psw_out   <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        a_out   <= nxt_a;
        b_out   <= nxt_b;
        psw_out <= {nxt_cy, nxt_ac, psw_in[5:3], nxt_ov, psw_in[1], nxt_p};
      end
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [W-1:0]     a_in,
  input logic [W-1:0]     b_in,
  input logic [PSW_W-1:0] psw_in,
  input logic             res_valid,
  input logic [W-1:0]     a_out,
  input logic [W-1:0]     b_out,
  input logic [PSW_W-1:0] psw_out
);
  localparam int DW = 2 * W;

  logic [1:0] unused_bits;
  assign unused_bits = {psw_in[PSW_CY], psw_in[PSW_P]};

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(a_out) && $stable(b_out) && $stable(psw_out));

  // R7
  mul_place_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_code) == OP_MUL |->
      {b_out, a_out} == DW'($past(a_in)) * DW'($past(b_in)) && !psw_out[PSW_CY]);

  // R8
  div_result_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_code) == OP_DIV && $past(b_in) != '0 |->
      (DW'(a_out) * DW'($past(b_in)) + DW'(b_out) == DW'($past(a_in)))
      && (b_out < $past(b_in)));

  // R9
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_code) == OP_DIV && $past(b_in) == '0 |->
      psw_out[PSW_OV] && !psw_out[PSW_CY] && a_out == $past(a_in));

  // R10
  setc_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(op_code) == OP_SETC |->
      psw_out[PSW_CY] && psw_out[PSW_AC] == $past(psw_in[PSW_AC])
      && psw_out[PSW_OV] == $past(psw_in[PSW_OV]));

  // R11
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> psw_out[PSW_P] == ^a_out);

  // R12
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> psw_out[5:3] == $past(psw_in[5:3]) && psw_out[1] == $past(psw_in[1]));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .a_in(a_in), .b_in(b_in), .psw_in(psw_in), .res_valid(res_valid),
  .a_out(a_out), .b_out(b_out), .psw_out(psw_out)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_code = '0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [7:0]   psw_in = '0;
  logic         res_valid;
  logic [W-1:0] a_out, b_out;
  logic [7:0]   psw_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  alu_flag_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .a_in(a_in), .b_in(b_in), .psw_in(psw_in), .res_valid(res_valid),
    .a_out(a_out), .b_out(b_out), .psw_out(psw_out)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] psw;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t model(int op, int a, int b, logic [7:0] psw, string tag);
    exp_t e;
    int ra = a, rb = b, c = int'(psw[7]), t, sa, sb;
    logic cy = psw[7], ac = psw[6], ov = psw[2], par = 1'b0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        t  = a + b + c;
        ra = t % 256;
        cy = (t > 255);
        ac = ((a % 16) + (b % 16) + c) > 15;
        ov = (sa + sb + c > 127) || (sa + sb + c < -128);
      end
      2: begin
        t  = a - b - c;
        ra = (t + 512) % 256;
        cy = (t < 0);
        ac = ((a % 16) - (b % 16) - c) < 0;
        ov = (sa - sb - c > 127) || (sa - sb - c < -128);
      end
      3: begin
        t  = a * b;
        ra = t % 256;
        rb = t / 256;
        cy = 1'b0;
        ov = (t > 255);
      end
      4: begin
        cy = 1'b0;
        if (b == 0) ov = 1'b1;
        else begin
          ra = a / b;
          rb = a % b;
          ov = 1'b0;
        end
      end
      5: cy = 1'b1;
      6: cy = 1'b0;
      default: ra = b;
    endcase
    for (int i = 0; i < 8; i++) par = par ^ ra[i];
    e.a   = 8'(ra);
    e.b   = 8'(rb);
    e.psw = {cy, ac, psw[5:3], ov, psw[1], par};
    e.tag = tag;
    return e;
  endfunction

  task automatic issue(int op, int a, int b, logic [7:0] psw, string tag);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = 3'(op);
    a_in     = 8'(a);
    b_in     = 8'(b);
    psw_in   = psw;
    exp_q.push_back(model(op, a, b, psw, tag));
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 3'd7;
    a_in     = 8'hA5;
    b_in     = 8'h5A;
    psw_in   = 8'hFF;
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected result a=%h b=%h psw=%h, expected none", a_out, b_out, psw_out);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (a_out !== e.a || b_out !== e.b || psw_out !== e.psw) begin
          n_fail++;
          $display("FAIL %s: a=%h b=%h psw=%b, expected a=%h b=%h psw=%b",
                   e.tag, a_out, b_out, psw_out, e.a, e.b, e.psw);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] ha, hb, hp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (res_valid !== 1'b0 || a_out !== '0 || b_out !== '0 || psw_out !== '0) begin
      n_fail++;
      $display("FAIL R1: valid=%b a=%h b=%h psw=%h, expected all zero", res_valid, a_out, b_out, psw_out);
    end
    rst = 1'b0;

    // R3 add and add with carry
    issue(0, 8'h3A, 8'h25, 8'h00, "R3");
    issue(0, 8'hFF, 8'h01, 8'h00, "R3");
    issue(1, 8'h10, 8'h20, 8'h80, "R3");
    issue(1, 8'hF0, 8'h0F, 8'h80, "R3");
    // R4 half carry / half borrow
    issue(0, 8'h0F, 8'h01, 8'h00, "R4");
    issue(2, 8'h10, 8'h01, 8'h00, "R4");
    // R5 signed overflow
    issue(0, 8'h7F, 8'h01, 8'h00, "R5");
    issue(2, 8'h80, 8'h01, 8'h00, "R5");
    issue(0, 8'h80, 8'h80, 8'h00, "R5");
    // R6 subtract with borrow
    issue(2, 8'h05, 8'h07, 8'h00, "R6");
    issue(2, 8'h50, 8'h20, 8'h80, "R6");
    // R7 multiply
    issue(3, 8'h50, 8'h0A, 8'h80, "R7");
    issue(3, 8'h03, 8'h04, 8'h84, "R7");
    issue(3, 8'hFF, 8'hFF, 8'h00, "R7");
    // R8 divide
    issue(4, 8'hFB, 8'h12, 8'h80, "R8");
    issue(4, 8'h07, 8'h09, 8'h04, "R8");
    issue(4, 8'hFF, 8'h01, 8'h00, "R8");
    // R9 divide by zero
    issue(4, 8'h44, 8'h00, 8'h80, "R9");
    // R10 carry set / clear
    issue(5, 8'h12, 8'h34, 8'h44, "R10");
    issue(6, 8'h12, 8'h34, 8'hC4, "R10");
    // R11 copy and parity
    issue(7, 8'h00, 8'h07, 8'h00, "R11");
    issue(7, 8'hFF, 8'h03, 8'h01, "R11");
    // R12 pass-through bits
    issue(0, 8'h01, 8'h01, 8'h3A, "R12");
    issue(3, 8'h02, 8'h02, 8'h3A, "R12");
    go_idle();
    @(negedge clk);
    ha = a_out; hb = b_out; hp = psw_out;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_valid !== 1'b0 || a_out !== ha || b_out !== hb || psw_out !== hp) begin
      n_fail++;
      $display("FAIL R2: idle valid=%b a=%h b=%h psw=%h, expected 0 %h %h %h",
               res_valid, a_out, b_out, psw_out, ha, hb, hp);
    end
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule